// File: doc/BRIEF.md
# LPC Memory-Cycle Target Controller

This block is the bus-facing half of a firmware-storage device on a Low Pin Count bus. It watches the 4-bit multiplexed LAD lines and the active-low frame signal, clocked by the PCI clock. It recognises single-byte memory read and memory write cycles and assembles the 32-bit address. The block responds only when three strap-selected address bits match the device's own identity. Address bit 23 sends each access either to the storage array or to register space. The block does not contain the storage itself. It hands the decoded offset, the space selection and the write byte to a back end, and it takes the read byte from that back end.

On a read, the target takes the bus after the host's turnaround and holds the host off with a fixed, parameterised number of short-wait SYNC clocks. It then signals ready and returns the byte as two nibbles, low nibble first, before it gives the bus back. On a write, it collects the two data nibbles and strobes the byte to the back end only after the high nibble has arrived. It then answers with a single ready SYNC. If the host drops the frame signal at any point, the current cycle ends and the target releases the bus on the next clock.

Top module: `lpc_mem_target`

## Requirements
- R1: A cycle starts only from the last clock edge at which `frame_n` is low. That nibble must be 0000b. If a nibble other than 0000b is sampled while `frame_n` is still low, no cycle starts. Several low-frame clocks whose last nibble is 0000b start exactly one cycle.
- R2: The nibble after START selects the cycle. 0100b and 0101b select a memory read. 0110b and 0111b select a memory write. Bit 0 has no effect. Any nibble whose bits 3:2 are not 01b gives no response: `lad_oe` stays low and neither `rd_req` nor `wr_stb` pulses.
- R3: The next eight nibbles form the address, most significant nibble first. While a request is presented, `be_addr` carries address bits 19:0, and `be_array` carries bit 23 (1 = array, 0 = register space).
- R4: The target answers only when address bits 22:20 equal `id_strap`. Otherwise the cycle gets no response in the R2 sense.
- R5: Read timing, counted from START as clock 1: clocks 11–12 are undriven (`lad_oe` low). The target drives 0101b on clocks 13 to 12+WAITS. It drives 0000b on clock 13+WAITS, the low data nibble on 14+WAITS, the high nibble on 15+WAITS and 1111b on 16+WAITS. `lad_oe` is low on clock 17+WAITS.
- R6: `rd_req` is high for exactly one clock on a responding read: the last short-wait clock, 12+WAITS. The byte on `be_rdata` in that clock is the byte returned.
- R7: Write timing: the low data nibble is on clock 11 and the high nibble on clock 12. Clocks 13–14 are undriven. The target drives 0000b on clock 15 and 1111b on clock 16. `lad_oe` is low on clock 17.
- R8: `wr_stb` is high for exactly one clock, clock 13, on a responding write. In that clock `be_wdata` is the received byte (low nibble from clock 11).
- R9: If `frame_n` is sampled low during a cycle, `lad_oe` is low on the next clock. The target then decodes the next START normally. An abort sampled on or before the high write-data nibble produces no `wr_stb`.
- R10: While `rst` is high or `init_n` is low, the target is held idle. `lad_oe` is low on the next clock, no strobe is issued, and the cycle in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock (PCI clock) |
| rst | input | 1 | Synchronous reset, active high |
| init_n | input | 1 | Processor init, active low, acts like reset |
| frame_n | input | 1 | Frame signal from the host, active low |
| lad_in | input | 4 | Sampled LAD nibble |
| lad_out | output | 4 | Nibble the target drives on LAD |
| lad_oe | output | 1 | LAD output enable; LAD floats when low |
| id_strap | input | ID_W | Strapped device identity |
| rd_req | output | 1 | Read request to the back end, one clock |
| wr_stb | output | 1 | Write strobe to the back end, one clock |
| be_array | output | 1 | 1 = storage array, 0 = register space |
| be_addr | output | OFFS_W | Byte offset of the access |
| be_wdata | output | 8 | Write byte |
| be_rdata | input | 8 | Read byte from the back end, valid while `rd_req` is high |

## Verification
The assertions assume that the host follows the frame protocol. Once a cycle has started, `frame_n` is high except to abort or to begin a new START. The host never drives LAD while the target owns it. They also assume that `be_rdata` is valid in the cycle in which `rd_req` is high. The bench drives every nibble on the falling edge and sends aborts only as low-frame clocks. Its back-end model computes the read byte combinationally from the presented offset and space selection, so the data is always ready in the sampling clock.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TYPE,
    ST_ADDR,
    ST_WLO,
    ST_WHI,
    ST_HTAR1,
    ST_HTAR2,
    ST_WAIT,
    ST_SYNC,
    ST_DLO,
    ST_DHI,
    ST_TTAR
  } lpc_state_e;

  localparam logic [3:0] NIB_START = 4'h0;
  localparam logic [3:0] NIB_WAIT  = 4'h5;
  localparam logic [3:0] NIB_READY = 4'h0;
  localparam logic [3:0] NIB_TAR   = 4'hF;
  localparam logic [1:0] TYPE_MEM  = 2'b01;
endpackage

// File: rtl/lpc_tgt_counter.sv
module lpc_tgt_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (clr)      cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lpc_tgt_capture.sv
module lpc_tgt_capture #(
  parameter int KEEP_W = 24
) (
  input  logic              clk,
  input  logic              shift_en,
  input  logic              lo_en,
  input  logic              hi_en,
  input  logic [3:0]        nib,
  output logic [KEEP_W-1:0] addr_q,
  output logic [KEEP_W-1:0] addr_nxt,
  output logic [7:0]        data_q
);
  assign addr_nxt = {addr_q[KEEP_W-5:0], nib};

  always_ff @(posedge clk) begin
    if (shift_en) addr_q <= addr_nxt;
    if (lo_en)    data_q[3:0] <= nib;
    if (hi_en)    data_q[7:4] <= nib;
  end
endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target
  import lpc_tgt_pkg::*;
#(
  parameter int WAITS  = 2,
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 20,
  parameter int ID_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_n,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  input  logic [ID_W-1:0]   id_strap,
  output logic              rd_req,
  output logic              wr_stb,
  output logic              be_array,
  output logic [OFFS_W-1:0] be_addr,
  output logic [7:0]        be_wdata,
  input  logic [7:0]        be_rdata
);
  localparam int ADDR_NIBS = ADDR_W / 4;
  localparam int SEL_BIT   = OFFS_W + ID_W;
  localparam int KEEP_W    = SEL_BIT + 1;
  localparam int MAXC      = (ADDR_NIBS > WAITS) ? ADDR_NIBS : WAITS;
  localparam int CNT_W     = $clog2(MAXC) + 1;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAITS - 1);

  lpc_state_e        state;
  logic              is_wr;
  logic              hold;
  logic              abort;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_clr;
  logic              cnt_inc;
  logic [KEEP_W-1:0] addr_q;
  logic [KEEP_W-1:0] addr_nxt;
  logic [7:0]        data_q;
  logic [7:0]        rdata_q;
  logic              id_hit;

  assign hold  = rst || !init_n;
  assign abort = !frame_n;

  assign cnt_clr = hold || abort || (state == ST_TYPE) || (state == ST_HTAR2);
  assign cnt_inc = (state == ST_ADDR) || (state == ST_WAIT);

  lpc_tgt_counter #(.W(CNT_W)) u_cnt (
    .clk (clk),
    .clr (cnt_clr),
    .inc (cnt_inc),
    .cnt (cnt)
  );

  lpc_tgt_capture #(.KEEP_W(KEEP_W)) u_cap (
    .clk      (clk),
    .shift_en (frame_n && state == ST_ADDR),
    .lo_en    (frame_n && state == ST_WLO),
    .hi_en    (frame_n && state == ST_WHI),
    .nib      (lad_in),
    .addr_q   (addr_q),
    .addr_nxt (addr_nxt),
    .data_q   (data_q)
  );

  assign id_hit   = (addr_nxt[OFFS_W +: ID_W] == id_strap);
  assign be_array = addr_q[SEL_BIT];
  assign be_addr  = addr_q[OFFS_W-1:0];
  assign be_wdata = data_q;
  assign rd_req   = (state == ST_WAIT) && (cnt == WAIT_LAST);

  always_ff @(posedge clk) begin
    wr_stb <= 1'b0;
    if (hold) begin
      state  <= ST_IDLE;
      lad_oe <= 1'b0;
      is_wr  <= 1'b0;
    end else if (abort) begin
      lad_oe <= 1'b0;
      state  <= (lad_in == NIB_START) ? ST_TYPE : ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: state <= ST_IDLE;
        ST_TYPE: begin
          is_wr <= lad_in[1];
          state <= (lad_in[3:2] == TYPE_MEM) ? ST_ADDR : ST_IDLE;
        end
        ST_ADDR: begin
          if (cnt == ADDR_LAST) begin
            if (!id_hit)    state <= ST_IDLE;
            else if (is_wr) state <= ST_WLO;
            else            state <= ST_HTAR1;
          end
        end
        ST_WLO: state <= ST_WHI;
        ST_WHI: begin
          wr_stb <= 1'b1;
          state  <= ST_HTAR1;
        end
        ST_HTAR1: state <= ST_HTAR2;
        ST_HTAR2: begin
          lad_oe  <= 1'b1;
          lad_out <= is_wr ? NIB_READY : NIB_WAIT;
          state   <= is_wr ? ST_SYNC : ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt == WAIT_LAST) begin
            rdata_q <= be_rdata;
            lad_out <= NIB_READY;
            state   <= ST_SYNC;
          end
        end
        ST_SYNC: begin
          lad_out <= is_wr ? NIB_TAR : rdata_q[3:0];
          state   <= is_wr ? ST_TTAR : ST_DLO;
        end
        ST_DLO: begin
          lad_out <= rdata_q[7:4];
          state   <= ST_DHI;
        end
        ST_DHI: begin
          lad_out <= NIB_TAR;
          state   <= ST_TTAR;
        end
        ST_TTAR: begin
          lad_oe <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lpc_mem_target_chk.sv
module lpc_mem_target_chk (
  input logic       clk,
  input logic       rst,
  input logic       init_n,
  input logic       frame_n,
  input logic [3:0] lad_out,
  input logic       lad_oe,
  input logic       rd_req,
  input logic       wr_stb
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R10: held idle while reset or init is active
  p_idle_in_reset_r10: assert property (@(posedge clk) disable iff (!armed)
    (rst || !init_n) |=> (!lad_oe && !wr_stb));

  // R9: frame low releases LAD on the next clock
  p_release_on_frame_r9: assert property (@(posedge clk) disable iff (rst || !init_n)
    !frame_n |=> !lad_oe);

  // R8: write strobe only after a high-frame sample, and for one clock
  p_wr_after_frame_high_r8: assert property (@(posedge clk) disable iff (rst || !init_n)
    wr_stb |-> $past(frame_n));
  p_wr_one_clock_r8: assert property (@(posedge clk) disable iff (rst || !init_n)
    wr_stb |=> !wr_stb);

  // R5 / R7: the first driven nibble is always a SYNC code
  p_first_drive_sync_r5: assert property (@(posedge clk) disable iff (rst || !init_n)
    $rose(lad_oe) |-> (lad_out == 4'h5 || lad_out == 4'h0));

  // R7: a normal release is preceded by a 1111b clock
  p_release_after_tar_r7: assert property (@(posedge clk) disable iff (rst || !init_n)
    ($fell(lad_oe) && $past(frame_n) && $past(init_n) && !$past(rst)) |-> $past(lad_out) == 4'hF);

  // R6: read request only while short-wait is driven; never with a write strobe
  p_rdreq_in_wait_r6: assert property (@(posedge clk) disable iff (rst || !init_n)
    rd_req |-> (lad_oe && lad_out == 4'h5));
  p_strobes_exclusive_r6: assert property (@(posedge clk) disable iff (rst || !init_n)
    $onehot0({rd_req, wr_stb}));
endmodule

bind lpc_mem_target lpc_mem_target_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .init_n  (init_n),
  .frame_n (frame_n),
  .lad_out (lad_out),
  .lad_oe  (lad_oe),
  .rd_req  (rd_req),
  .wr_stb  (wr_stb)
);

// File: tb/lpc_mem_target_bench.sv
module lpc_mem_target_bench;
  localparam int CLK_PERIOD = 30;
  localparam int N_WAIT     = 2;
  localparam logic [2:0] MY_ID = 3'b010;
  localparam int WDOG       = 20000;
  localparam int NVEC       = 9;

  // {cycle-type nibble, address, write byte}
  localparam logic [43:0] VEC [NVEC] = '{
    {4'h4, 32'hFFA1_2345, 8'h00},
    {4'h5, 32'h00A0_00FF, 8'h00},
    {4'h6, 32'hFFAF_FFFF, 8'h3C},
    {4'h7, 32'hFF2A_BCDE, 8'hC3},
    {4'h4, 32'h0020_0010, 8'h00},
    {4'h4, 32'hFFB1_2345, 8'h00},
    {4'h8, 32'hFFA1_2345, 8'h00},
    {4'h2, 32'hFFA1_2345, 8'h00},
    {4'h6, 32'hFFE0_0000, 8'h77}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        init_n = 1'b1;
  logic        frame_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic        rd_req;
  logic        wr_stb;
  logic        be_array;
  logic [19:0] be_addr;
  logic [7:0]  be_wdata;
  logic [7:0]  be_rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rd_model(input logic arr, input logic [19:0] off);
    return off[7:0] ^ off[15:8] ^ (arr ? 8'h5A : 8'hC6);
  endfunction

  assign be_rdata = rd_model(be_array, be_addr);

  lpc_mem_target #(.WAITS(N_WAIT)) u_lpc_mem_target (
    .clk(clk), .rst(rst), .init_n(init_n), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .id_strap(MY_ID), .rd_req(rd_req),
    .wr_stb(wr_stb), .be_array(be_array), .be_addr(be_addr), .be_wdata(be_wdata),
    .be_rdata(be_rdata)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic fr, input logic [3:0] nib);
    frame_n = fr;
    lad_in  = nib;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [4:0] bus_obs();
    return {lad_oe, lad_oe ? lad_out : 4'h0};
  endfunction

  function automatic logic [3:0] nib_for(input int k, input logic [3:0] ct,
                                         input logic [31:0] a, input logic [7:0] wd);
    if (k == 1) return 4'h0;
    if (k == 2) return ct;
    if (k <= 10) return a[31-4*(k-3) -: 4];
    if (ct[1] && k == 11) return wd[3:0];
    if (ct[1] && k == 12) return wd[7:4];
    return 4'hF;
  endfunction

  // Full cycle, checking every clock against the timing requirements.
  task automatic bus_cycle(input logic [3:0] ct, input logic [31:0] a, input logic [7:0] wd);
    bit   is_wr = ct[1];
    bit   resp  = (ct[3:2] == 2'b01) && (a[22:20] == MY_ID);
    logic [7:0] rd = rd_model(a[23], a[19:0]);
    int   total = is_wr ? 18 : 18 + N_WAIT;
    string tag  = !resp ? ((ct[3:2] != 2'b01) ? "R2" : "R4") : (is_wr ? "R7" : "R5");
    for (int k = 1; k <= total; k++) begin
      int c;
      logic [4:0] exp;
      bit exp_rd, exp_wr;
      step(k == 1 ? 1'b0 : 1'b1, nib_for(k, ct, a, wd));
      c = k + 1;
      exp = 5'h00;
      if (resp && !is_wr) begin
        if (c >= 13 && c <= 12 + N_WAIT) exp = 5'h15;
        else if (c == 13 + N_WAIT)       exp = 5'h10;
        else if (c == 14 + N_WAIT)       exp = {1'b1, rd[3:0]};
        else if (c == 15 + N_WAIT)       exp = {1'b1, rd[7:4]};
        else if (c == 16 + N_WAIT)       exp = 5'h1F;
      end else if (resp) begin
        if (c == 15)      exp = 5'h10;
        else if (c == 16) exp = 5'h1F;
      end
      chk(bus_obs() == exp, tag, $sformatf("LAD clock %0d", c), 32'(bus_obs()), 32'(exp));
      exp_rd = resp && !is_wr && (c == 12 + N_WAIT);
      exp_wr = resp && is_wr && (c == 13);
      chk(rd_req == exp_rd, "R6", $sformatf("rd_req clock %0d", c), 32'(rd_req), 32'(exp_rd));
      chk(wr_stb == exp_wr, "R8", $sformatf("wr_stb clock %0d", c), 32'(wr_stb), 32'(exp_wr));
      if (exp_rd || exp_wr) begin
        chk(be_addr == a[19:0], "R3", "offset", 32'(be_addr), 32'(a[19:0]));
        chk(be_array == a[23], "R3", "space select", 32'(be_array), 32'(a[23]));
      end
      if (exp_wr) chk(be_wdata == wd, "R8", "write byte", 32'(be_wdata), 32'(wd));
    end
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 4'hF);
      chk(!lad_oe && !wr_stb && !rd_req, tag, "quiet bus",
          32'({lad_oe, wr_stb, rd_req}), 32'h0);
    end
  endtask

  initial begin
    @(negedge clk);
    step(1'b1, 4'hF);
    step(1'b1, 4'hF);
    chk(!lad_oe && !wr_stb && !rd_req, "R10", "reset state", 32'({lad_oe, wr_stb, rd_req}), 32'h0);
    rst = 1'b0;
    quiet(2, "R10");

    // Table-driven cycles
    for (int v = 0; v < NVEC; v++) begin
      bus_cycle(VEC[v][43:40], VEC[v][39:8], VEC[v][7:0]);
      quiet(1, "R2");
    end

    // R1: extra low-frame clocks, last nibble 0000b, start one cycle
    step(1'b0, 4'h3);
    chk(!lad_oe, "R1", "oe during leading frame", 32'(lad_oe), 32'h0);
    step(1'b0, 4'h0);
    bus_cycle(4'h4, 32'h00A1_0042, 8'h00);
    quiet(1, "R1");

    // R1: START followed by a non-zero low-frame nibble starts nothing
    step(1'b0, 4'h0);
    step(1'b0, 4'h5);
    for (int k = 2; k <= 18 + N_WAIT; k++) begin
      step(1'b1, nib_for(k, 4'h4, 32'hFFA1_2345, 8'h00));
      chk(!lad_oe && !rd_req, "R1", "cancelled start", 32'({lad_oe, rd_req}), 32'h0);
    end

    // R9: abort a read while short-wait SYNC is driven
    for (int k = 1; k <= 12; k++) step(k == 1 ? 1'b0 : 1'b1, nib_for(k, 4'h4, 32'hFFA0_1111, 8'h00));
    chk(lad_oe && lad_out == 4'h5, "R5", "wait before abort", 32'({lad_oe, lad_out}), 32'h15);
    step(1'b0, 4'hF);
    chk(!lad_oe, "R9", "release after abort", 32'(lad_oe), 32'h0);
    quiet(4, "R9");
    bus_cycle(4'h4, 32'hFFA0_2222, 8'h00);

    // R9: abort on the high write nibble gives no strobe
    for (int k = 1; k <= 11; k++) step(k == 1 ? 1'b0 : 1'b1, nib_for(k, 4'h6, 32'hFFA0_3333, 8'h99));
    step(1'b0, 4'h9);
    quiet(8, "R9");

    // R9: a new START during a write restarts decoding
    for (int k = 1; k <= 5; k++) step(k == 1 ? 1'b0 : 1'b1, nib_for(k, 4'h6, 32'hFFA0_4444, 8'h11));
    bus_cycle(4'h6, 32'hFFA0_5555, 8'hE1);

    // R10: init low mid-read abandons the cycle and holds idle
    for (int k = 1; k <= 13; k++) step(k == 1 ? 1'b0 : 1'b1, nib_for(k, 4'h4, 32'hFFA0_6666, 8'h00));
    chk(lad_oe, "R5", "driving before init", 32'(lad_oe), 32'h1);
    init_n = 1'b0;
    step(1'b1, 4'hF);
    chk(!lad_oe, "R10", "release on init", 32'(lad_oe), 32'h0);
    step(1'b0, 4'h0);
    init_n = 1'b1;
    for (int k = 2; k <= 18 + N_WAIT; k++) begin
      step(1'b1, nib_for(k, 4'h4, 32'hFFA0_6666, 8'h00));
      chk(!lad_oe && !rd_req, "R10", "start ignored under init", 32'({lad_oe, rd_req}), 32'h0);
    end
    bus_cycle(4'h6, 32'hFFA0_7777, 8'h5D);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule